// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects interrupt requests from up to 31 groups of four sources each and presents them to a processor as two signals. The first is a non-maskable interrupt line fed by the two lowest groups. The second is a 3-bit priority level naming the most urgent pending maskable group. Sources arrive as one-clock request pulses. Each pulse sets a sticky request bit, which stays set until software clears it through the register bus.

Groups 0 and 1 are non-maskable. Their four enables are fixed on. Groups 2 to 30 each carry four enable bits and a programmable 3-bit level, where a smaller number means more urgent. When the processor takes an interrupt, it pulses the acknowledge input. The block then records the group that was winning. Software can read that group back from an acceptance register. The read returns zero if that group's enabled request has since gone away.

The register bus is one byte wide, with a write strobe and a read strobe. Read data appears on the clock after the read strobe.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset all request bits are 0, the enables of the maskable groups are 0 and their levels are 0, the enables of groups 0 and 1 are all 1, `lvl_out` is 7 and `nmi_out` is 0.
- R2: A pulse on `src_pulse[4*g+i]` sets request bit i of group g. When a register write clears that bit in the same cycle, the pulse wins.
- R3: `lvl_out` equals the smallest level among groups 2..30 whose request AND enable is nonzero. It is 7 when no such group exists, so a pending group at level 7 leaves it at 7. It is registered and follows a state change one clock later.
- R4: When several qualifying groups share the smallest level, the group with the lower index is the winner.
- R5: Bus addresses with bit 7 clear reach group `addr[6:2]`, byte `addr[1:0]`. Addresses with bit 7 set reach the acceptance register. Unmapped bytes and group indices 31 and above read as 0. `bus_rdata` is loaded on the clock edge that samples `bus_re`.
- R6: Reading byte 0 of a maskable group gives the request bits in [7:4] and request AND enable in [3:0]. Reading byte 1 gives the level in [6:4] and the enables in [3:0], with bit 7 zero.
- R7: Writing byte 0 of a maskable group treats [7:4] as a mask M and [3:0] as data D. Per bit, M=1,D=1 sets the request, M=0,D=1 clears it, and D=0 leaves it unchanged.
- R8: Writing byte 1 of a maskable group loads the level from [6:4] and the enables from [3:0].
- R9: For groups 0 and 1, reading byte 0 returns the request bits in [3:0]. Writing byte 0 clears the bits written as 1, and writing byte 3 sets them. Writes to byte 1 leave the enables all set.
- R10: `nmi_out` goes to 1 one clock after any of groups 0 and 1 has request AND enable nonzero, and to 0 one clock after none does.
- R11: `ack` records the group behind the current `lvl_out`, which is group 0 when none qualifies. Acceptance byte 0 (address 0x80) reads that index times 4, or 0 if its request AND enable is now zero. Byte 1 reads 0, and writes to the acceptance register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 124 | One-cycle request pulses, bit 4*g+i is source i of group g |
| ack | input | 1 | Interrupt acknowledge strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the clock after `bus_re` |
| lvl_out | output | 3 | Level of the winning maskable group, 7 when idle |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
Arbitration is tested with several patterns:
- A single enabled group, which checks the basic level path.
- A request on a disabled source, which shows that masking is applied.
- A more urgent group at a higher index, which shows that the level decides before the index does.
- Two groups at an equal level, which shows the tie-break on index.
- A pending group at level 7, which separates strict comparison from non-strict comparison.

All four mask/data combinations of the request write are applied to one group and read back. A pulse is also made to collide with a clearing write. The acceptance register is read three ways: while its group is still live, after that group has been cleared, and after an attempted write. These reads tell a recorded index apart from a live one.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int SRC_W  = 4;
  localparam int LVL_W  = 3;
  localparam int BYTE_W = 8;

  typedef logic [SRC_W-1:0] src_t;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_IDLE = '1;

  // per-bit: M&D sets, ~M&D clears, D==0 keeps
  function automatic src_t req_merge(src_t cur, src_t m, src_t d);
    return (m & d) | (m & cur) | (~m & ~d & cur);
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(src_t req, src_t en);
    return {req, req & en};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_ctrl(lvl_t lv, src_t en);
    return {1'b0, lv, en};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_nmi(src_t req);
    return {{(BYTE_W-SRC_W){1'b0}}, req};
  endfunction
endpackage

// File: rtl/irq_grp_bank.sv
module irq_grp_bank
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_GROUPS = 31,
  parameter int NUM_NMI    = 2,
  parameter int ADDR_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  src_t [NUM_GROUPS-1:0]   pulse,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTE_W-1:0]       wdata,
  output src_t [NUM_GROUPS-1:0]   req_q,
  output src_t [NUM_GROUPS-1:0]   en_q,
  output lvl_t [NUM_GROUPS-1:0]   lvl_q
);
  localparam int GF_W = ADDR_W - 3;

  src_t wr_mask;
  src_t wr_data;
  lvl_t wr_lvl;
  assign wr_mask = wdata[2*SRC_W-1:SRC_W];
  assign wr_data = wdata[SRC_W-1:0];
  assign wr_lvl  = wdata[SRC_W+LVL_W-1:SRC_W];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = we && !addr[ADDR_W-1] && (addr[ADDR_W-2:2] == GF_W'(g));

    src_t req_r, req_nx;

    if (g < NUM_NMI) begin : g_nmi
      always_comb begin
        req_nx = req_r;
        if (hit && addr[1:0] == 2'd0) req_nx = req_r & ~wr_data;
        else if (hit && addr[1:0] == 2'd3) req_nx = req_r | wr_data;
        req_nx = req_nx | pulse[g];
      end
      always_ff @(posedge clk) begin
        if (!rst_n) req_r <= '0;
        else        req_r <= req_nx;
      end
      assign en_q[g]  = '1;
      assign lvl_q[g] = '0;
    end else begin : g_lvl
      src_t en_r;
      lvl_t lv_r;
      always_comb begin
        req_nx = req_r;
        if (hit && addr[1:0] == 2'd0) req_nx = req_merge(req_r, wr_mask, wr_data);
        req_nx = req_nx | pulse[g];
      end
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          req_r <= '0;
          en_r  <= '0;
          lv_r  <= '0;
        end else begin
          req_r <= req_nx;
          if (hit && addr[1:0] == 2'd1) begin
            en_r <= wr_data;
            lv_r <= wr_lvl;
          end
        end
      end
      assign en_q[g]  = en_r;
      assign lvl_q[g] = lv_r;
    end

    assign req_q[g] = req_r;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_GROUPS = 31,
  parameter int NUM_NMI    = 2,
  localparam int GID_W     = $clog2(NUM_GROUPS)
) (
  input  src_t [NUM_GROUPS-1:0] req,
  input  src_t [NUM_GROUPS-1:0] en,
  input  lvl_t [NUM_GROUPS-1:0] lvl,
  output logic [GID_W-1:0]      win_idx,
  output lvl_t                  win_lvl,
  output logic                  nmi_pend
);
  // ascending scan, strictly smaller level replaces: lower index wins ties
  always_comb begin
    win_idx = '0;
    win_lvl = LVL_IDLE;
    for (int g = NUM_NMI; g < NUM_GROUPS; g++) begin
      if (|(req[g] & en[g]) && (lvl[g] < win_lvl)) begin
        win_idx = GID_W'(g);
        win_lvl = lvl[g];
      end
    end
  end

  always_comb begin
    nmi_pend = 1'b0;
    for (int g = 0; g < NUM_NMI; g++) nmi_pend = nmi_pend | (|(req[g] & en[g]));
  end
endmodule

// File: rtl/irq_readout.sv
module irq_readout
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_GROUPS = 31,
  parameter int NUM_NMI    = 2,
  parameter int ADDR_W     = 8,
  localparam int GID_W     = $clog2(NUM_GROUPS)
) (
  input  logic [ADDR_W-1:0]     addr,
  input  src_t [NUM_GROUPS-1:0] req,
  input  src_t [NUM_GROUPS-1:0] en,
  input  lvl_t [NUM_GROUPS-1:0] lvl,
  input  logic [GID_W-1:0]      acc_idx,
  output logic [BYTE_W-1:0]     rd_val
);
  localparam int GF_W = ADDR_W - 3;

  logic acc_live;
  always_comb begin
    acc_live = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (acc_idx == GID_W'(g)) acc_live = |(req[g] & en[g]);
  end

  always_comb begin
    rd_val = '0;
    if (addr[ADDR_W-1]) begin
      if (addr[ADDR_W-2:0] == '0 && acc_live)
        rd_val = BYTE_W'({acc_idx, 2'b00});
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (addr[ADDR_W-2:2] == GF_W'(g)) begin
          if (g < NUM_NMI) begin
            if (addr[1:0] == 2'd0) rd_val = pack_nmi(req[g]);
          end else begin
            if (addr[1:0] == 2'd0)      rd_val = pack_status(req[g], en[g]);
            else if (addr[1:0] == 2'd1) rd_val = pack_ctrl(lvl[g], en[g]);
          end
        end
      end
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_GROUPS = 31,
  parameter int NUM_NMI    = 2,
  parameter int ADDR_W     = 8,
  localparam int GID_W     = $clog2(NUM_GROUPS),
  localparam int SRC_TOT   = NUM_GROUPS * SRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_TOT-1:0] src_pulse,
  input  logic               ack,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BYTE_W-1:0]  bus_wdata,
  input  logic               bus_we,
  input  logic               bus_re,
  output logic [BYTE_W-1:0]  bus_rdata,
  output logic [LVL_W-1:0]   lvl_out,
  output logic               nmi_out
);
  src_t [NUM_GROUPS-1:0] pulse_a;
  src_t [NUM_GROUPS-1:0] req_a;
  src_t [NUM_GROUPS-1:0] en_a;
  lvl_t [NUM_GROUPS-1:0] lvl_a;
  assign pulse_a = src_pulse;

  logic [GID_W-1:0]  win_idx;
  lvl_t              win_lvl;
  logic              nmi_pend;
  logic [GID_W-1:0]  win_q;
  logic [GID_W-1:0]  acc_q;
  logic [BYTE_W-1:0] rd_val;

  irq_grp_bank #(.NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .pulse(pulse_a), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .req_q(req_a), .en_q(en_a), .lvl_q(lvl_a)
  );

  irq_arbiter #(.NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI)) u_arb (
    .req(req_a), .en(en_a), .lvl(lvl_a),
    .win_idx(win_idx), .win_lvl(win_lvl), .nmi_pend(nmi_pend)
  );

  irq_readout #(.NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI), .ADDR_W(ADDR_W)) u_rd (
    .addr(bus_addr), .req(req_a), .en(en_a), .lvl(lvl_a),
    .acc_idx(acc_q), .rd_val(rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_out   <= LVL_IDLE;
      nmi_out   <= 1'b0;
      win_q     <= '0;
      acc_q     <= '0;
      bus_rdata <= '0;
    end else begin
      lvl_out <= win_lvl;
      nmi_out <= nmi_pend;
      win_q   <= win_idx;
      if (ack)    acc_q     <= win_q;
      if (bus_re) bus_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_GROUPS = 31,
  parameter int NUM_NMI    = 2,
  parameter int ADDR_W     = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_GROUPS*SRC_W-1:0] src_pulse,
  input src_t [NUM_GROUPS-1:0]       req_q,
  input src_t [NUM_GROUPS-1:0]       en_q,
  input logic [LVL_W-1:0]            lvl_out,
  input logic                        nmi_out,
  input logic                        bus_re,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [BYTE_W-1:0]           bus_rdata
);
  localparam logic [ADDR_W-1:0] ACC_ADDR = ADDR_W'(1) << (ADDR_W-1);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic [NUM_GROUPS*SRC_W-1:0] req_flat;
  assign req_flat = req_q;

  logic lvl_any, nmi_any, nmi_en_full;
  always_comb begin
    lvl_any = 1'b0;
    for (int g = NUM_NMI; g < NUM_GROUPS; g++) lvl_any = lvl_any | (|(req_q[g] & en_q[g]));
    nmi_any = 1'b0;
    nmi_en_full = 1'b1;
    for (int g = 0; g < NUM_NMI; g++) begin
      nmi_any = nmi_any | (|(req_q[g] & en_q[g]));
      nmi_en_full = nmi_en_full & (&en_q[g]);
    end
  end

  p_pulse_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((req_flat & $past(src_pulse)) == $past(src_pulse)));

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(lvl_any)) |-> (lvl_out == LVL_IDLE));

  p_nmi_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_en_full);

  p_nmi_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (nmi_out == $past(nmi_any)));

  p_acc_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bus_re) && $past(bus_addr) == ACC_ADDR) |-> (bus_rdata[1:0] == 2'b00));
endmodule

bind grp_irq_ctrl irq_ctrl_chk #(
  .NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .req_q(req_a), .en_q(en_a),
  .lvl_out(lvl_out), .nmi_out(nmi_out), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/sim_grp_irq_ctrl.sv
`timescale 1ns/1ps
module sim_grp_irq_ctrl;
  localparam int NG = 31;
  localparam int NS = NG * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_pulse = '0;
  logic          ack = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [7:0]    bus_rdata;
  logic [2:0]    lvl_out;
  logic          nmi_out;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  grp_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .ack(ack),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .lvl_out(lvl_out), .nmi_out(nmi_out)
  );

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input int g, input int i);
    src_pulse[g*4+i] = 1'b1;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic rd_chk(input string rq, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(rq, v, exp);
  endtask

  task automatic t_reset();
    chk("R1 lvl_out", lvl_out, 7);
    chk("R1 nmi_out", nmi_out, 0);
    rd_chk("R1 grp2 ctrl", 8'h09, 8'h00);
    rd_chk("R1 grp0 req", 8'h00, 8'h00);
    rd_chk("R1 grp30 status", 8'h78, 8'h00);
  endtask

  task automatic t_level();
    wr(8'h15, 8'h3F); pulse(5, 1); settle();
    chk("R3 single group", lvl_out, 3);
    rd_chk("R6 status", 8'h14, 8'h22);
    rd_chk("R8 ctrl read", 8'h15, 8'h3F);
    wr(8'h25, 8'h11); pulse(9, 2); settle();
    chk("R3 masked source", lvl_out, 3);
    rd_chk("R6 masked status", 8'h24, 8'h40);
    wr(8'h25, 8'h14); settle();
    chk("R8 enable load", lvl_out, 1);
    wr(8'h24, 8'h04); settle();
    chk("R7 clear M0D1", lvl_out, 3);
    rd_chk("R7 cleared", 8'h24, 8'h00);
    wr(8'h14, 8'h80); rd_chk("R7 keep M1D0", 8'h14, 8'h22);
    wr(8'h14, 8'h88); rd_chk("R7 set M1D1", 8'h14, 8'hAA);
    wr(8'h14, 8'h02); rd_chk("R7 clear one", 8'h14, 8'h88);
    wr(8'h14, 8'h00); rd_chk("R7 keep M0D0", 8'h14, 8'h88);
    wr(8'h14, 8'h0F); settle();
    chk("R3 idle again", lvl_out, 7);
    wr(8'h11, 8'h7F); pulse(4, 0); settle();
    chk("R3 level seven", lvl_out, 7);
    wr(8'h10, 8'h0F);
  endtask

  task automatic t_pulse_write();
    logic [7:0] v;
    bus_addr = 8'h14; bus_wdata = 8'h0F; bus_we = 1'b1; src_pulse[20] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; src_pulse = '0;
    rd(8'h14, v);
    chk("R2 pulse beats clear", v, 8'h11);
    settle();
    chk("R2 level from pulse", lvl_out, 3);
    wr(8'h14, 8'h0F); settle();
  endtask

  task automatic t_tie();
    wr(8'h0D, 8'h21); wr(8'h1D, 8'h21);
    pulse(7, 0); pulse(3, 0); settle();
    chk("R4 tie level", lvl_out, 2);
    do_ack();
    rd_chk("R4 tie lower index", 8'h80, 8'd12);
    pulse(9, 2); settle();
    chk("R3 urgent higher index", lvl_out, 1);
    do_ack();
    rd_chk("R11 accept idx9", 8'h80, 8'd36);
    wr(8'h24, 8'h04); settle();
    chk("R4 back to tie", lvl_out, 2);
    wr(8'h0C, 8'h01); settle();
    chk("R4 remaining group", lvl_out, 2);
    do_ack();
    rd_chk("R11 accept idx7", 8'h80, 8'd28);
    wr(8'h1C, 8'h01);
    rd_chk("R11 vanished", 8'h80, 8'h00);
    pulse(7, 0);
    rd_chk("R11 live again", 8'h80, 8'd28);
    rd_chk("R11 byte1", 8'h81, 8'h00);
    wr(8'h80, 8'hFF);
    rd_chk("R11 write ignored", 8'h80, 8'd28);
    settle();
    chk("R11 write no level effect", lvl_out, 2);
    wr(8'h1C, 8'h01); settle();
    do_ack();
    rd_chk("R11 idle ack", 8'h80, 8'h00);
  endtask

  task automatic t_nmi();
    pulse(1, 2); settle();
    chk("R10 nmi set", nmi_out, 1);
    chk("R3 nmi no level", lvl_out, 7);
    rd_chk("R9 nmi read", 8'h04, 8'h04);
    wr(8'h05, 8'h00); settle();
    chk("R9 enables fixed", nmi_out, 1);
    wr(8'h04, 8'h04); settle();
    chk("R9 clear", nmi_out, 0);
    wr(8'h03, 8'h01); settle();
    chk("R9 byte3 set", nmi_out, 1);
    rd_chk("R9 grp0 read", 8'h00, 8'h01);
    wr(8'h00, 8'h0F); settle();
    chk("R10 nmi drop", nmi_out, 0);
  endtask

  task automatic t_unmapped();
    rd_chk("R5 group31", 8'h7C, 8'h00);
    rd_chk("R5 byte2", 8'h16, 8'h00);
    rd_chk("R5 acc byte2", 8'h82, 8'h00);
    rd_chk("R5 nmi byte1", 8'h01, 8'h00);
    rd_chk("R5 mapped", 8'h15, 8'h3F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_level();
    t_pulse_write();
    t_tie();
    t_nmi();
    t_unmapped();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule